// File: doc/BRIEF.md
# Buffer Length Control Smoother

This block converts a stream of 10-bit control-knob conversions into a 16-bit delay-buffer length that changes gradually. It sums the conversions in blocks of 256. At the end of each block it divides the sum by four and raises the result to a floor of 0x0200 if it is below that. The result becomes the new target length only if it differs from the present target by a clear margin. Before it is stored, the target is forced even.

A second register holds the live length seen by the audio path. On each audio sample tick it walks toward the target in steps of two. The delay therefore glides to the new size and never jumps. Both lengths come out of reset at 0x0600.

The target update is sequenced by a three-state machine:
- WAIT idles until a block completes (WAIT→CLAMP, taking the block result).
- CLAMP applies the floor (CLAMP→JUDGE, always).
- JUDGE applies the deadband and commits an even target (JUDGE→WAIT, always).

Top module: `buflen_smoother`

## Requirements
- R1: After reset, `cur_len` and `tgt_len` both read 0x0600.
- R2: After every 256 conversions accepted with `adc_valid` high, the block result is the 24-bit sum of those conversions shifted right by 2, truncated to 16 bits.
- R3: A cycle with `adc_valid` low adds nothing to the sum and does not advance the conversion count, whatever `adc_data` holds.
- R4: A block result below 0x0200 is replaced by 0x0200 before it is compared, so `tgt_len` is never below 0x0200.
- R5: `tgt_len` takes the clamped result only when their absolute difference is at least 0x0040. A difference of 0x003F or less leaves `tgt_len` unchanged, and a difference of exactly 0x0040 updates it.
- R6: When `tgt_len` is updated, bit 0 of the stored value is cleared, so `tgt_len` is always even.
- R7: On each cycle with `sample_tick` high, `cur_len` moves 2 toward `tgt_len`, or holds when they are equal. Without a tick it does not change, and it never passes the target.
- R8: The sum is cleared at the end of each block, so each block result depends only on its own 256 conversions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | A conversion is present on `adc_data` this cycle |
| adc_data | input | 10 | Unsigned conversion value |
| sample_tick | input | 1 | One-cycle pulse per audio sample period |
| cur_len | output | 16 | Live buffer length, slewed |
| tgt_len | output | 16 | Target buffer length |

## Verification
The hardest state to reach from the ports is a block result that falls exactly on a deadband edge or on an odd value. An even value repeated 256 times can only produce multiples of 64. The bench therefore builds each block from 255 equal conversions plus one final conversion that carries the remainder, which sets the sum, and so the result, to any chosen value. This is how it places results at a difference of 0x3F, at exactly 0x40, at an odd value and below the floor. Invalid cycles carrying full-scale data are woven into the blocks to show they leave no trace.

// File: rtl/bls_pkg.sv
package bls_pkg;
    typedef enum logic [1:0] {
        TS_WAIT  = 2'd0,
        TS_CLAMP = 2'd1,
        TS_JUDGE = 2'd2
    } tgt_state_e;
endpackage

// File: rtl/bls_accum.sv
module bls_accum #(
    parameter int ADC_W     = 10,
    parameter int ACC_W     = 24,
    parameter int LEN_W     = 16,
    parameter int BLK_LOG2  = 8,
    parameter int AVG_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_data,
    output logic             blk_done,
    output logic [LEN_W-1:0] blk_cand
);
    localparam int CNT_W = BLK_LOG2;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] sum_next;
    logic [ACC_W-1:0] sum_shift;

    assign sum_next  = acc_q + ACC_W'(adc_data);
    assign sum_shift = sum_next >> AVG_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            blk_done <= 1'b0;
            blk_cand <= '0;
        end else begin
            blk_done <= 1'b0;
            if (adc_valid) begin
                cnt_q <= cnt_q + 1'b1;
                if (&cnt_q) begin
                    // last conversion of the block: publish and restart
                    blk_cand <= sum_shift[LEN_W-1:0];
                    blk_done <= 1'b1;
                    acc_q    <= '0;
                end else begin
                    acc_q <= sum_next;
                end
            end
        end
    end
endmodule

// File: rtl/bls_target.sv
module bls_target
    import bls_pkg::*;
#(
    parameter int          LEN_W    = 16,
    parameter logic [15:0] MIN_LEN  = 16'h0200,
    parameter logic [15:0] DEADBAND = 16'h0040,
    parameter logic [15:0] INIT_LEN = 16'h0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_done,
    input  logic [LEN_W-1:0] blk_cand,
    output logic [LEN_W-1:0] tgt_len
);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] DB_L   = LEN_W'(DEADBAND);
    localparam logic [LEN_W-1:0] INIT_L = LEN_W'(INIT_LEN);

    tgt_state_e       state_q, state_d;
    logic [LEN_W-1:0] hold_q;
    logic [LEN_W-1:0] gap;

    assign gap = (hold_q >= tgt_len) ? (hold_q - tgt_len) : (tgt_len - hold_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_WAIT:  if (blk_done) state_d = TS_CLAMP;
            TS_CLAMP: state_d = TS_JUDGE;
            TS_JUDGE: state_d = TS_WAIT;
            default:  state_d = TS_WAIT;
        endcase
    end

    // datapath registers driven per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tgt_len <= INIT_L;
        end else begin
            unique case (state_q)
                TS_WAIT:  if (blk_done) hold_q <= blk_cand;
                TS_CLAMP: if (hold_q < MIN_L) hold_q <= MIN_L;
                TS_JUDGE: if (gap >= DB_L) tgt_len <= {hold_q[LEN_W-1:1], 1'b0};
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/bls_slew.sv
module bls_slew #(
    parameter int          LEN_W    = 16,
    parameter int          STEP     = 2,
    parameter logic [15:0] INIT_LEN = 16'h0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [LEN_W-1:0] tgt_len,
    output logic [LEN_W-1:0] cur_len
);
    localparam logic [LEN_W-1:0] STEP_L = LEN_W'(STEP);

    logic [LEN_W-1:0] up_gap, dn_gap;
    assign up_gap = tgt_len - cur_len;
    assign dn_gap = cur_len - tgt_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_len <= LEN_W'(INIT_LEN);
        end else if (sample_tick) begin
            if (cur_len < tgt_len)
                cur_len <= (up_gap < STEP_L) ? tgt_len : cur_len + STEP_L;
            else if (cur_len > tgt_len)
                cur_len <= (dn_gap < STEP_L) ? tgt_len : cur_len - STEP_L;
        end
    end
endmodule

// File: rtl/buflen_smoother.sv
module buflen_smoother #(
    parameter int          ADC_W     = 10,
    parameter int          ACC_W     = 24,
    parameter int          LEN_W     = 16,
    parameter int          BLK_LOG2  = 8,
    parameter int          AVG_SHIFT = 2,
    parameter int          STEP      = 2,
    parameter logic [15:0] MIN_LEN   = 16'h0200,
    parameter logic [15:0] DEADBAND  = 16'h0040,
    parameter logic [15:0] INIT_LEN  = 16'h0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             sample_tick,
    output logic [LEN_W-1:0] cur_len,
    output logic [LEN_W-1:0] tgt_len
);
    logic             blk_done;
    logic [LEN_W-1:0] blk_cand;

    bls_accum #(
        .ADC_W(ADC_W), .ACC_W(ACC_W), .LEN_W(LEN_W),
        .BLK_LOG2(BLK_LOG2), .AVG_SHIFT(AVG_SHIFT)
    ) accum_i (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
        .blk_done(blk_done), .blk_cand(blk_cand)
    );

    bls_target #(
        .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .DEADBAND(DEADBAND), .INIT_LEN(INIT_LEN)
    ) target_i (
        .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .blk_cand(blk_cand),
        .tgt_len(tgt_len)
    );

    bls_slew #(
        .LEN_W(LEN_W), .STEP(STEP), .INIT_LEN(INIT_LEN)
    ) slew_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .tgt_len(tgt_len),
        .cur_len(cur_len)
    );
endmodule

// File: rtl/buflen_smoother_chk.sv
module buflen_smoother_chk #(
    parameter int          LEN_W   = 16,
    parameter logic [15:0] MIN_LEN = 16'h0200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic [LEN_W-1:0] cur_len,
    input logic [LEN_W-1:0] tgt_len
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R6
    tgt_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_len[0] == 1'b0);

    // R4
    tgt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_len >= LEN_W'(MIN_LEN));

    // R7
    cur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(sample_tick)) |-> $stable(cur_len));

    // R7
    cur_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(sample_tick) && $past(cur_len) < $past(tgt_len))
            |-> (cur_len == $past(cur_len) + LEN_W'(2)));

    // R7
    cur_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(sample_tick) && $past(cur_len) > $past(tgt_len))
            |-> (cur_len == $past(cur_len) - LEN_W'(2)));

    // R7
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cur_len) == $past(tgt_len)) |-> $stable(cur_len));
endmodule

bind buflen_smoother buflen_smoother_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .cur_len(cur_len), .tgt_len(tgt_len)
);

// File: tb/buflen_smoother_tb.sv
module buflen_smoother_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_valid = 1'b0;
    logic [9:0]  adc_data = '0;
    logic        sample_tick = 1'b0;
    logic [15:0] cur_len, tgt_len;

    int checks = 0;
    int errors = 0;
    int exp_cur = 16'h0600;
    int exp_tgt = 16'h0600;

    always #10 clk = ~clk;

    buflen_smoother dut_i (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
        .sample_tick(sample_tick), .cur_len(cur_len), .tgt_len(tgt_len)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // requirement model of the target update
    function automatic void model_block(input int cand);
        int c = (cand < 16'h0200) ? 16'h0200 : cand;
        int d = (c > exp_tgt) ? c - exp_tgt : exp_tgt - c;
        if (d >= 16'h0040) exp_tgt = c & 16'hFFFE;
    endfunction

    // 256 valid conversions whose sum is 4*cand; invalid full-scale cycles woven in
    task automatic feed_block(input int cand, input bit stop_early);
        int total = 4 * cand;
        int base  = total / 256;
        int last  = total - 255 * base;
        for (int i = 0; i < 256; i++) begin
            if (stop_early && i == 255) break;
            @(negedge clk);
            adc_valid = 1'b1;
            adc_data  = 10'((i == 255) ? last : base);
            if (i % 16 == 7) begin
                @(negedge clk);
                adc_valid = 1'b0;
                adc_data  = 10'h3FF;
            end
        end
        @(negedge clk);
        adc_valid = 1'b0;
        adc_data  = 10'h3FF;
        repeat (6) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_tick = 1'b1;
            if (exp_cur < exp_tgt) exp_cur += 2;
            else if (exp_cur > exp_tgt) exp_cur -= 2;
            @(negedge clk);
            sample_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1 cur", cur_len, 16'h0600);
        check("R1 tgt", tgt_len, 16'h0600);
        ticks(1);
        check("R7 hold at equal", cur_len, 16'h0600);
    endtask

    task automatic t_average;
        feed_block(16'h1900, 1'b1);
        check("R3 no update before 256 valid", tgt_len, 16'h0600);
        @(negedge clk);
        adc_valid = 1'b1;
        adc_data  = 10'd100;
        @(negedge clk);
        adc_valid = 1'b0;
        adc_data  = 10'h3FF;
        repeat (6) @(negedge clk);
        model_block(16'h1900);
        check("R2 average of block", tgt_len, exp_tgt);
        check("R7 no tick no move", cur_len, 16'h0600);
    endtask

    task automatic t_slew_up;
        ticks(5);
        check("R7 rise by 2 per tick", cur_len, exp_cur);
        ticks((exp_tgt - exp_cur) / 2);
        check("R7 reaches target", cur_len, exp_tgt);
        ticks(3);
        check("R7 no overshoot", cur_len, exp_tgt);
    endtask

    task automatic t_deadband;
        feed_block(16'h193F, 1'b0);
        model_block(16'h193F);
        check("R5 diff 0x3F ignored / R8 fresh sum", tgt_len, 16'h1900);
        feed_block(16'h18C0, 1'b0);
        model_block(16'h18C0);
        check("R5 diff exactly 0x40 updates", tgt_len, 16'h18C0);
    endtask

    task automatic t_even;
        feed_block(16'h1A01, 1'b0);
        model_block(16'h1A01);
        check("R6 odd result made even", tgt_len, 16'h1A00);
    endtask

    task automatic t_clamp;
        feed_block(16'h0100, 1'b0);
        model_block(16'h0100);
        check("R4 clamp to floor", tgt_len, 16'h0200);
        feed_block(0, 1'b0);
        model_block(0);
        check("R4 zero block stays at floor", tgt_len, 16'h0200);
    endtask

    task automatic t_slew_down;
        ticks(3);
        check("R7 fall by 2 per tick", cur_len, exp_cur);
        ticks((exp_cur - exp_tgt) / 2);
        check("R7 reaches lower target", cur_len, 16'h0200);
        ticks(2);
        check("R7 holds at target", cur_len, 16'h0200);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_average();
        t_slew_up();
        t_deadband();
        t_even();
        t_clamp();
        t_slew_down();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule